// File: doc/BRIEF.md
# HDLC Serial Receive Deframer

This block sits behind a demodulator and clock-recovery stage. It takes one line bit per cycle in which `bit_en` is high and turns the stream back into HDLC frames. A bit on the line that keeps its level decodes as a one, and a bit that changes level decodes as a zero. The deframer hunts for the flag pattern in the decoded stream and drops the zeros that the sender inserted after each run of five ones. It packs the frame body into bytes and checks the 16-bit frame check sequence with a bit-serial CRC register as the bits arrive.

Payload bytes come out one at a time, each with a one-cycle `out_valid` strobe. `out_sof` marks the first byte of a frame. The two bytes of the check sequence are never shown as payload, because every byte is held back until two newer bytes have arrived. When a frame ends, a separate one-cycle `out_eof` strobe carries the verdict on `out_good` or `out_bad`. A frame ends at a closing flag or at an abort. A closing flag may also serve as the opening flag of the next frame.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: Each line bit taken while `bit_en` is high decodes to 1 when it equals the previous line bit and to 0 when it differs. The reference level after reset is 0.
- R2: The decoded pattern 0,1,1,1,1,1,1,0 is a flag, and a flag opens a frame. Flags with no body bits between them produce no output strobe of any kind.
- R3: Inside a frame, a decoded 0 that follows exactly five consecutive decoded 1s is discarded and is not part of the frame body.
- R4: Seven consecutive decoded 1s inside a frame abort it. If any body bit had been accepted, one `out_eof` with `out_bad` follows. After an abort nothing further is output until a new flag is seen.
- R5: Body bits are packed least significant bit first into 8-bit bytes. Each payload byte appears on `out_byte` with a one-cycle `out_valid`, one clock after the `bit_en` cycle that completed the byte that releases it.
- R6: The last 16 body bits before the closing flag are never output. A frame of N body bytes produces exactly N-2 payload bytes, or none if N is 2 or less.
- R7: `out_sof` is high together with `out_valid` on the first payload byte of each frame and on no other byte.
- R8: The check register is preset to 0xFFFF at every flag or abort. It shifts right by one bit per body bit, and when bit 0 XOR the body bit is 1 it is XORed with 0x8408. The check passes when the register holds 0xF0B8 at the closing flag. This is the value that results when the sender appends the complement of its register, least significant bit first.
- R9: A closed frame is reported bad when its body length is not a whole number of bytes or is shorter than 24 bits, even if the check passes.
- R10: A single flag can close one frame and open the next. The second frame is received in full, and its first byte carries `out_sof`.
- R11: A frame that ends at a closing flag after at least one body bit produces exactly one `out_eof`, one clock after the final flag bit. `out_eof` is never high together with `out_valid`, and exactly one of `out_good` and `out_bad` is high with it and only then.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Qualifies `line_bit` for this cycle |
| line_bit | input | 1 | Differentially coded line bit |
| out_byte | output | 8 | Payload byte |
| out_valid | output | 1 | `out_byte` is valid this cycle |
| out_sof | output | 1 | Marks the first payload byte of a frame |
| out_eof | output | 1 | Frame has ended |
| out_good | output | 1 | Frame passed all checks (with `out_eof`) |
| out_bad | output | 1 | Frame failed or was aborted (with `out_eof`) |

## Verification
The closing of one frame and the opening of the next land on the same line bit whenever two frames share a flag. On that bit the end verdict must be issued, and the check register, byte packer and holdback buffer must all be cleared for the new frame. The bench provokes this by sending most random frames back to back with a single flag between them. It judges each frame on its own: the payload bytes and their count, `out_sof` on the first byte only, and exactly one verdict. Frames whose payload or check bytes end in runs of ones also put a discarded stuffed zero right before the shared flag.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

   // Default framing and check constants (reflected polynomial form).
   localparam int unsigned      DEF_BYTE_W    = 8;
   localparam int unsigned      DEF_FCS_W     = 16;
   localparam int unsigned      DEF_RUN_STUFF = 5;
   localparam logic [15:0]      DEF_POLY_REV  = 16'h8408;
   localparam logic [15:0]      DEF_PRESET    = 16'hFFFF;
   localparam logic [15:0]      DEF_RESIDUE   = 16'hF0B8;

   // What a decoded bit means for the frame layer.
   typedef enum logic [1:0] {
      LN_BODY  = 2'd0,
      LN_STUFF = 2'd1,
      LN_FLAG  = 2'd2,
      LN_ABORT = 2'd3
   } line_class_e;

endpackage

// File: rtl/hdlc_line_decode.sv
module hdlc_line_decode #(
   parameter bit   DIFF_CODED = 1'b1,
   parameter logic LINE_INIT  = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_en,
   input  logic line_bit,
   output logic dec_bit
);

   generate
      if (DIFF_CODED) begin : g_diff
         logic prev_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      prev_q <= LINE_INIT;
            else if (bit_en) prev_q <= line_bit;
         end

         // Unchanged level decodes as one, a transition as zero.
         assign dec_bit = ~(line_bit ^ prev_q);

         assert_prev_tracks_line_R1: assert property (@(posedge clk) disable iff (!rst_n)
            bit_en |=> (prev_q == $past(line_bit)));
      end else begin : g_plain
         logic unused_ok;
         assign unused_ok = ^{clk, rst_n, bit_en};
         assign dec_bit   = line_bit;
      end
   endgenerate

endmodule

// File: rtl/hdlc_flag_destuff.sv
module hdlc_flag_destuff
   import hdlc_rx_pkg::*;
#(
   parameter int unsigned RUN_STUFF = DEF_RUN_STUFF
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_en,
   input  logic dec_bit,
   output logic body_bit,
   output logic body_stb,
   output logic ev_flag,
   output logic ev_abort
);

   localparam int unsigned FLAG_RUN  = RUN_STUFF + 1;
   localparam int unsigned ABORT_RUN = RUN_STUFF + 2;
   localparam int unsigned DELAY     = RUN_STUFF + 2;   // flag length minus its last bit
   localparam int unsigned CNT_W     = $clog2(ABORT_RUN + 1);
   localparam int unsigned FILL_W    = $clog2(DELAY + 1);

   logic [CNT_W-1:0]  ones_q;
   logic              in_frame_q;
   logic [DELAY-1:0]  dly_q;
   logic [FILL_W-1:0] fill_q;
   line_class_e       cls;
   logic              push;

   always_comb begin
      cls = LN_BODY;
      if (!dec_bit && ones_q == CNT_W'(RUN_STUFF))      cls = LN_STUFF;
      else if (!dec_bit && ones_q == CNT_W'(FLAG_RUN))  cls = LN_FLAG;
      else if (dec_bit && ones_q == CNT_W'(FLAG_RUN))   cls = LN_ABORT;
   end

   assign push     = bit_en && in_frame_q && (cls == LN_BODY);
   assign body_stb = push && (fill_q == FILL_W'(DELAY));
   assign body_bit = dly_q[DELAY-1];
   assign ev_flag  = bit_en && (cls == LN_FLAG);
   assign ev_abort = bit_en && in_frame_q && (cls == LN_ABORT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ones_q     <= '0;
         in_frame_q <= 1'b0;
         dly_q      <= '0;
         fill_q     <= '0;
      end else if (bit_en) begin
         if (!dec_bit)                         ones_q <= '0;
         else if (ones_q != CNT_W'(ABORT_RUN)) ones_q <= ones_q + CNT_W'(1);

         if (cls == LN_FLAG) begin
            in_frame_q <= 1'b1;
            fill_q     <= '0;
         end else if (cls == LN_ABORT) begin
            in_frame_q <= 1'b0;
            fill_q     <= '0;
         end else if (push) begin
            dly_q <= {dly_q[DELAY-2:0], dec_bit};
            if (fill_q != FILL_W'(DELAY)) fill_q <= fill_q + FILL_W'(1);
         end
      end
   end

   assert_flag_clears_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ev_flag |=> !body_stb);
   assert_abort_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ev_abort |=> !body_stb);

endmodule

// File: rtl/hdlc_fcs_check.sv
module hdlc_fcs_check
   import hdlc_rx_pkg::*;
#(
   parameter int unsigned       FCS_W    = DEF_FCS_W,
   parameter logic [FCS_W-1:0]  POLY_REV = DEF_POLY_REV,
   parameter logic [FCS_W-1:0]  PRESET   = DEF_PRESET,
   parameter logic [FCS_W-1:0]  RESIDUE  = DEF_RESIDUE
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic bit_stb,
   input  logic bit_in,
   output logic match
);

   logic [FCS_W-1:0] crc_q;
   logic             fb;

   assign fb    = crc_q[0] ^ bit_in;
   assign match = (crc_q == RESIDUE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       crc_q <= PRESET;
      else if (clear)   crc_q <= PRESET;
      else if (bit_stb) crc_q <= (crc_q >> 1) ^ (fb ? POLY_REV : '0);
   end

   assert_preset_on_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (crc_q == PRESET));

endmodule

// File: rtl/hdlc_byte_holdback.sv
module hdlc_byte_holdback #(
   parameter int unsigned BYTE_W     = 8,
   parameter int unsigned HOLD_BYTES = 2,
   parameter int unsigned MIN_BYTES  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              body_bit,
   input  logic              body_stb,
   input  logic              ev_flag,
   input  logic              ev_abort,
   input  logic              fcs_match,
   output logic [BYTE_W-1:0] out_byte,
   output logic              out_valid,
   output logic              out_sof,
   output logic              out_eof,
   output logic              out_good,
   output logic              out_bad
);

   localparam int unsigned POS_W = $clog2(BYTE_W);
   localparam int unsigned NB_W  = $clog2(MIN_BYTES + 1);
   localparam int unsigned HC_W  = $clog2(HOLD_BYTES + 1);

   logic [BYTE_W-1:0] asm_q;
   logic [POS_W-1:0]  pos_q;
   logic [NB_W-1:0]   nbytes_q;
   logic [HC_W-1:0]   hcnt_q;
   logic              sof_pend_q;
   logic [BYTE_W-1:0] hold_w [HOLD_BYTES];
   logic [BYTE_W-1:0] new_byte;
   logic              byte_done, hold_full, has_data, frame_ok, frame_end;

   assign new_byte  = {body_bit, asm_q[BYTE_W-1:1]};
   assign byte_done = body_stb && (pos_q == POS_W'(BYTE_W - 1));
   assign hold_full = (hcnt_q == HC_W'(HOLD_BYTES));
   assign has_data  = (nbytes_q != '0) || (pos_q != '0);
   assign frame_ok  = (pos_q == '0) && (nbytes_q == NB_W'(MIN_BYTES)) && fcs_match;
   assign frame_end = ev_flag || ev_abort;

   // One register per holdback slot; a full buffer shifts toward slot 0.
   generate
      for (genvar i = 0; i < HOLD_BYTES; i++) begin : g_slot
         logic [BYTE_W-1:0] slot_q;
         logic [BYTE_W-1:0] slot_in;
         if (i == HOLD_BYTES - 1) begin : g_tail
            assign slot_in = new_byte;
         end else begin : g_mid
            assign slot_in = hold_full ? hold_w[i+1] : new_byte;
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) slot_q <= '0;
            else if (byte_done && !frame_end && (hold_full || hcnt_q == HC_W'(i)))
               slot_q <= slot_in;
         end
         assign hold_w[i] = slot_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         asm_q      <= '0;
         pos_q      <= '0;
         nbytes_q   <= '0;
         hcnt_q     <= '0;
         sof_pend_q <= 1'b1;
         out_byte   <= '0;
         out_valid  <= 1'b0;
         out_sof    <= 1'b0;
         out_eof    <= 1'b0;
         out_good   <= 1'b0;
         out_bad    <= 1'b0;
      end else begin
         out_valid <= 1'b0;
         out_sof   <= 1'b0;
         out_eof   <= 1'b0;
         out_good  <= 1'b0;
         out_bad   <= 1'b0;
         if (frame_end) begin
            if (has_data) begin
               out_eof  <= 1'b1;
               out_good <= ev_flag && frame_ok;
               out_bad  <= !(ev_flag && frame_ok);
            end
            pos_q      <= '0;
            nbytes_q   <= '0;
            hcnt_q     <= '0;
            sof_pend_q <= 1'b1;
         end else if (body_stb) begin
            asm_q <= new_byte;
            pos_q <= byte_done ? '0 : pos_q + POS_W'(1);
            if (byte_done) begin
               if (nbytes_q != NB_W'(MIN_BYTES)) nbytes_q <= nbytes_q + NB_W'(1);
               if (hold_full) begin
                  out_byte   <= hold_w[0];
                  out_valid  <= 1'b1;
                  out_sof    <= sof_pend_q;
                  sof_pend_q <= 1'b0;
               end else begin
                  hcnt_q <= hcnt_q + HC_W'(1);
               end
            end
         end
      end
   end

   assert_hold_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      hcnt_q <= HC_W'(HOLD_BYTES));
   assert_byte_after_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(body_stb));
   assert_sof_with_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_sof |-> out_valid);
   assert_eof_alone_R11: assert property (@(posedge clk) disable iff (!rst_n)
      out_eof |-> (!out_valid && $countones({out_good, out_bad}) == 1));
   assert_verdict_needs_eof_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (out_good || out_bad) |-> out_eof);
   assert_good_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_good |-> $past(ev_flag));

endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
   import hdlc_rx_pkg::*;
#(
   parameter int unsigned      BYTE_W       = DEF_BYTE_W,
   parameter int unsigned      FCS_W        = DEF_FCS_W,
   parameter int unsigned      RUN_STUFF    = DEF_RUN_STUFF,
   parameter int unsigned      MIN_PAYLOAD  = 1,
   parameter bit               DIFF_CODED   = 1'b1,
   parameter logic             LINE_INIT    = 1'b0,
   parameter logic [FCS_W-1:0] POLY_REV     = DEF_POLY_REV,
   parameter logic [FCS_W-1:0] PRESET       = DEF_PRESET,
   parameter logic [FCS_W-1:0] RESIDUE      = DEF_RESIDUE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic              line_bit,
   output logic [BYTE_W-1:0] out_byte,
   output logic              out_valid,
   output logic              out_sof,
   output logic              out_eof,
   output logic              out_good,
   output logic              out_bad
);

   localparam int unsigned HOLD_BYTES = FCS_W / BYTE_W;
   localparam int unsigned MIN_BYTES  = MIN_PAYLOAD + HOLD_BYTES;

   generate
      if (FCS_W % BYTE_W != 0) begin : g_err_fcs
         $error("FCS_W must be a whole number of bytes");
      end
      if (BYTE_W < 2) begin : g_err_byte
         $error("BYTE_W must be at least 2");
      end
      if (RUN_STUFF < 2) begin : g_err_run
         $error("RUN_STUFF must be at least 2");
      end
      if (MIN_PAYLOAD < 1) begin : g_err_min
         $error("MIN_PAYLOAD must be at least 1");
      end
   endgenerate

   logic dec_bit, body_bit, body_stb, ev_flag, ev_abort, fcs_match;

   hdlc_line_decode #(.DIFF_CODED(DIFF_CODED), .LINE_INIT(LINE_INIT)) u_decode (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .line_bit(line_bit), .dec_bit(dec_bit)
   );

   hdlc_flag_destuff #(.RUN_STUFF(RUN_STUFF)) u_destuff (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .dec_bit(dec_bit),
      .body_bit(body_bit), .body_stb(body_stb), .ev_flag(ev_flag), .ev_abort(ev_abort)
   );

   hdlc_fcs_check #(.FCS_W(FCS_W), .POLY_REV(POLY_REV), .PRESET(PRESET), .RESIDUE(RESIDUE)) u_fcs (
      .clk(clk), .rst_n(rst_n), .clear(ev_flag || ev_abort), .bit_stb(body_stb),
      .bit_in(body_bit), .match(fcs_match)
   );

   hdlc_byte_holdback #(.BYTE_W(BYTE_W), .HOLD_BYTES(HOLD_BYTES), .MIN_BYTES(MIN_BYTES)) u_hold (
      .clk(clk), .rst_n(rst_n), .body_bit(body_bit), .body_stb(body_stb),
      .ev_flag(ev_flag), .ev_abort(ev_abort), .fcs_match(fcs_match),
      .out_byte(out_byte), .out_valid(out_valid), .out_sof(out_sof),
      .out_eof(out_eof), .out_good(out_good), .out_bad(out_bad)
   );

endmodule

// File: tb/hdlc_rx_deframer_tb.sv
module hdlc_rx_deframer_tb;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_en = 1'b0;
   logic       line_bit = 1'b0;
   logic [7:0] out_byte;
   logic       out_valid, out_sof, out_eof, out_good, out_bad;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hdlc_rx_deframer u_dut (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .line_bit(line_bit),
      .out_byte(out_byte), .out_valid(out_valid), .out_sof(out_sof),
      .out_eof(out_eof), .out_good(out_good), .out_bad(out_bad)
   );

   // Output monitor
   logic [7:0] mon_byte [0:4095];
   bit         mon_sof  [0:4095];
   int         mon_n = 0;
   bit         ev_good  [0:1023];
   int         ev_n = 0;

   always @(negedge clk) begin
      if (rst_n && out_valid && mon_n < 4096) begin
         mon_byte[mon_n] = out_byte;
         mon_sof[mon_n]  = out_sof;
         mon_n++;
      end
      if (rst_n && out_eof && ev_n < 1024) begin
         ev_good[ev_n] = out_good && !out_bad;
         ev_n++;
      end
   end

   task automatic check(input int act, input int exp, input string req);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Line-side model
   logic       tx_lvl  = 1'b0;
   int         tx_ones = 0;
   logic [7:0] frame_buf [0:63];

   task automatic send_line(input logic lvl);
      line_bit = lvl;
      bit_en   = 1'b1;
      @(negedge clk);
      bit_en   = 1'b0;
      repeat ($urandom % 3) @(negedge clk);
   endtask

   task automatic send_dec(input logic b);
      if (!b) tx_lvl = ~tx_lvl;
      send_line(tx_lvl);
   endtask

   task automatic send_flag();
      send_dec(1'b0);
      repeat (6) send_dec(1'b1);
      send_dec(1'b0);
      tx_ones = 0;
   endtask

   task automatic send_body_bit(input logic b);
      send_dec(b);
      if (b) begin
         tx_ones++;
         if (tx_ones == 5) begin
            send_dec(1'b0);
            tx_ones = 0;
         end
      end else begin
         tx_ones = 0;
      end
   endtask

   task automatic send_body_byte(input logic [7:0] v);
      for (int i = 0; i < 8; i++) send_body_bit(v[i]);
   endtask

   function automatic logic [15:0] ref_fcs(input int n);
      logic [15:0] c = 16'hFFFF;
      for (int k = 0; k < n; k++)
         for (int i = 0; i < 8; i++) begin
            if (c[0] ^ frame_buf[k][i]) c = (c >> 1) ^ 16'h8408;
            else                        c = c >> 1;
         end
      return ~c;
   endfunction

   task automatic send_frame(input int n, input bit corrupt);
      logic [15:0] f;
      for (int k = 0; k < n; k++) send_body_byte(frame_buf[k]);
      f = ref_fcs(n);
      if (corrupt) f = f ^ 16'h0100;
      send_body_byte(f[7:0]);
      send_body_byte(f[15:8]);
   endtask

   task automatic settle();
      repeat (3) @(negedge clk);
   endtask

   task automatic check_frame(input int mb, input int eb, input int n, input bit good,
                              input string req);
      check(mon_n - mb, n, {req, " byte count"});
      for (int i = 0; i < n; i++) begin
         if (mb + i < mon_n) begin
            check(mon_byte[mb+i], frame_buf[i], {req, " byte"});
            check(mon_sof[mb+i], (i == 0), "R7 sof position");
         end
      end
      check(ev_n - eb, 1, "R11 one eof per frame");
      if (ev_n > eb) check(ev_good[eb], good, {req, " verdict"});
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      int mb, eb, n, dummy;
      bit bad;
      dummy = $urandom(32'h5EED_0042);

      // Reset state
      repeat (4) @(negedge clk);
      check({out_valid, out_sof, out_eof, out_good, out_bad}, 0, "R11 reset outputs idle");
      rst_n = 1'b1;
      @(negedge clk);

      // R2: idle flags yield nothing
      repeat (3) send_flag();
      settle();
      check(mon_n, 0, "R2 idle flags no bytes");
      check(ev_n, 0, "R2 idle flags no eof");

      // R3: payload rich in ones, forcing stuffed zeros
      frame_buf[0] = 8'hFF; frame_buf[1] = 8'h7E; frame_buf[2] = 8'hFF;
      frame_buf[3] = 8'h3E; frame_buf[4] = 8'hFC;
      mb = mon_n; eb = ev_n;
      send_frame(5, 1'b0);
      send_flag();
      settle();
      check_frame(mb, eb, 5, 1'b1, "R3 R8 stuffed payload");

      // R1 R5 R6 R10: random frames sharing single flags; some corrupted (R8)
      for (int f = 0; f < 30; f++) begin
         n = 1 + ($urandom % 12);
         for (int k = 0; k < n; k++)
            frame_buf[k] = (($urandom % 4) == 0) ? 8'hFF : 8'($urandom);
         bad = ((f % 5) == 4);
         mb = mon_n; eb = ev_n;
         send_frame(n, bad);
         send_flag();
         settle();
         check_frame(mb, eb, n, !bad, bad ? "R8 corrupted check" : "R1 R5 R6 R10 random frame");
      end

      // R9: body not a whole number of bytes (27 bits)
      frame_buf[0] = 8'h12; frame_buf[1] = 8'h34; frame_buf[2] = 8'h56;
      mb = mon_n; eb = ev_n;
      for (int k = 0; k < 3; k++) send_body_byte(frame_buf[k]);
      send_body_bit(1'b1); send_body_bit(1'b0); send_body_bit(1'b1);
      send_flag();
      settle();
      check_frame(mb, eb, 1, 1'b0, "R9 ragged length");

      // R9: check sequence only, no payload (valid residue, too short)
      mb = mon_n; eb = ev_n;
      send_frame(0, 1'b0);
      send_flag();
      settle();
      check_frame(mb, eb, 0, 1'b0, "R9 too short");

      // R4: abort after five bytes ending in zero bits
      frame_buf[0] = 8'h11; frame_buf[1] = 8'h22; frame_buf[2] = 8'h33;
      frame_buf[3] = 8'h44; frame_buf[4] = 8'h00;
      mb = mon_n; eb = ev_n;
      for (int k = 0; k < 5; k++) send_body_byte(frame_buf[k]);
      repeat (7) send_dec(1'b1);
      settle();
      check_frame(mb, eb, 2, 1'b0, "R4 abort");
      mb = mon_n; eb = ev_n;
      repeat (10) send_dec(1'b1);
      repeat (5) send_dec(1'b0);
      settle();
      check(mon_n - mb, 0, "R4 silent after abort bytes");
      check(ev_n - eb, 0, "R4 silent after abort eof");

      // Recovery after abort
      send_flag();
      frame_buf[0] = 8'hA5; frame_buf[1] = 8'h5A; frame_buf[2] = 8'hF0;
      mb = mon_n; eb = ev_n;
      send_frame(3, 1'b0);
      send_flag();
      settle();
      check_frame(mb, eb, 3, 1'b1, "R2 R4 resync frame");

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

endmodule